// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder (16-bit)

This block adds two 16-bit operands and a carry-in. All of its carries come from lookahead logic, not from a ripple chain. The operands are split into four 4-bit groups.

Inside each group, per-bit generate (AND) and propagate (OR) terms feed a fully expanded carry equation for every bit position. The same terms are reduced to one generate and one propagate for the group. A second lookahead unit of the same form takes the four group terms and the external carry-in. It produces every group's carry-in directly, with no path that passes from one group through the next.

The block-level generate and propagate terms are also driven out, so that a wider adder can stack another lookahead level on top of this one. The result, the carry-out and the block terms are captured in output registers. A synchronous active-high reset clears those registers.

Top module: `cla16_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge loads zero into `sum_q`, `carry_out_q`, `blk_prop_q` and `blk_gen_q`.
- R2: At a rising edge with `rst` low, `sum_q` takes the low 16 bits of `a_in + b_in + carry_in`, using the values present at that edge. The latency from input to output is one clock.
- R3: At the same edge, `carry_out_q` takes bit 16 of the 17-bit sum `a_in + b_in + carry_in`.
- R4: `blk_prop_q` is 1 exactly when every one of the 16 bit positions has `a_in` or `b_in` (or both) set. Propagate is the OR form, not the XOR form.
- R5: `blk_gen_q` is 1 exactly when `a_in + b_in` with no carry-in exceeds 16'hFFFF.
- R6: `carry_out_q` equals `blk_gen_q | (blk_prop_q & carry_in)`, where `carry_in` is the value sampled on the same edge.
- R7: A carry-in of 1 with operands whose bits all propagate (for example `a_in`=16'hFFFF, `b_in`=0) wraps `sum_q` to 0 and sets `carry_out_q` in the same single-cycle result.
- R8: The carry entering each 4-bit group (bits 4k+3..4k) equals the carry out of the sum of all lower bits and `carry_in`. The sum bits of every group are therefore correct for every combination of group operands and incoming carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs are registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a_in | input | 16 | First addend |
| b_in | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_q | output | 16 | Registered sum bits |
| carry_out_q | output | 1 | Registered carry out of bit 15 |
| blk_prop_q | output | 1 | Registered block propagate, for cascading |
| blk_gen_q | output | 1 | Registered block generate, for cascading |

## Verification
The hard case to reach from the ports is a single group's carry decision being exercised in every combination while the carry actually arrives through the second-level unit. Random operands seldom make every lower group propagate at once. The stimulus therefore sweeps each group through all 512 combinations of its two nibbles and the carry-in twice. In one pass all other groups are set to all-propagate (nibble F plus nibble 0), so a carry-in must cross every lower group through the group terms. In the other pass the other groups are zero, so nothing reaches the swept group from below. Fixed all-ones and wrap-around operands and a block of random vectors follow, and each result is compared against integer addition.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Generate/propagate pair handed from one lookahead level to the next.
  typedef struct packed {
    logic gen;
    logic prop;
  } pg_t;

  localparam int unsigned DEF_GRP_W = 4;
  localparam int unsigned DEF_GRP_N = 4;

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] bit_g,
  output logic [W-1:0] bit_p,
  output logic [W-1:0] half_sum
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_g[i]    = a[i] & b[i];
    assign bit_p[i]    = a[i] | b[i];
    assign half_sum[i] = a[i] ^ b[i];
  end

endmodule

// File: rtl/cla_lookahead.sv
// Fully expanded lookahead unit over N generate/propagate pairs.
// carry[i] is the carry entering position i (carry[0] = c_in).
// The group term summarises all N positions for the next level up.
module cla_lookahead
  import cla_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] g,
  input  logic [N-1:0] p,
  input  logic         c_in,
  output logic [N-1:0] carry,
  output pg_t          grp
);

  logic term_in;
  logic term_g;
  logic any_g;

  // Sum of products for every carry; no carry feeds another carry.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      term_in = c_in;
      for (int j = 0; j < i; j++) term_in = term_in & p[j];
      any_g = 1'b0;
      for (int j = 0; j < i; j++) begin
        term_g = g[j];
        for (int k = j + 1; k < i; k++) term_g = term_g & p[k];
        any_g = any_g | term_g;
      end
      carry[i] = term_in | any_g;
    end
  end

  logic grp_g_c;
  logic grp_p_c;
  logic run_g;

  always_comb begin
    grp_p_c = 1'b1;
    for (int j = 0; j < N; j++) grp_p_c = grp_p_c & p[j];
    grp_g_c = 1'b0;
    for (int j = 0; j < N; j++) begin
      run_g = g[j];
      for (int k = j + 1; k < N; k++) run_g = run_g & p[k];
      grp_g_c = grp_g_c | run_g;
    end
  end

  assign grp.gen  = grp_g_c;
  assign grp.prop = grp_p_c;

endmodule

// File: rtl/cla_group.sv
// One first-level group: bit terms, in-group lookahead, sum bits and
// the group generate/propagate for the second level.
module cla_group
  import cla_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output pg_t          grp
);

  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W-1:0] half_sum;
  logic [W-1:0] carry;

  cla_bit_pg #(.W(W)) u_pg (
    .a        (a),
    .b        (b),
    .bit_g    (bit_g),
    .bit_p    (bit_p),
    .half_sum (half_sum)
  );

  cla_lookahead #(.N(W)) u_la (
    .g     (bit_g),
    .p     (bit_p),
    .c_in  (c_in),
    .carry (carry),
    .grp   (grp)
  );

  // Sum uses the XOR of the inputs, never the OR propagate.
  assign sum = half_sum ^ carry;

endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla_pkg::*;
#(
  parameter int unsigned GRP_W = DEF_GRP_W,
  parameter int unsigned GRP_N = DEF_GRP_N
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [GRP_W*GRP_N-1:0] a_in,
  input  logic [GRP_W*GRP_N-1:0] b_in,
  input  logic                   carry_in,
  output logic [GRP_W*GRP_N-1:0] sum_q,
  output logic                   carry_out_q,
  output logic                   blk_prop_q,
  output logic                   blk_gen_q
);

  localparam int unsigned DATA_W = GRP_W * GRP_N;

  pg_t                grp_pg [GRP_N];
  logic [GRP_N-1:0]   grp_g;
  logic [GRP_N-1:0]   grp_p;
  logic [GRP_N-1:0]   grp_cin;
  logic [DATA_W-1:0]  sum_c;
  pg_t                blk_pg;
  logic               cout_c;

  // First level: independent groups, each fed by the second level.
  for (genvar k = 0; k < GRP_N; k++) begin : g_grp
    cla_group #(.W(GRP_W)) u_grp (
      .a    (a_in[k*GRP_W +: GRP_W]),
      .b    (b_in[k*GRP_W +: GRP_W]),
      .c_in (grp_cin[k]),
      .sum  (sum_c[k*GRP_W +: GRP_W]),
      .grp  (grp_pg[k])
    );
    assign grp_g[k] = grp_pg[k].gen;
    assign grp_p[k] = grp_pg[k].prop;
  end

  // Second level: every group carry computed directly from group terms.
  cla_lookahead #(.N(GRP_N)) u_lvl2 (
    .g     (grp_g),
    .p     (grp_p),
    .c_in  (carry_in),
    .carry (grp_cin),
    .grp   (blk_pg)
  );

  assign cout_c = blk_pg.gen | (blk_pg.prop & carry_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q       <= '0;
      carry_out_q <= 1'b0;
      blk_prop_q  <= 1'b0;
      blk_gen_q   <= 1'b0;
    end else begin
      sum_q       <= sum_c;
      carry_out_q <= cout_c;
      blk_prop_q  <= blk_pg.prop;
      blk_gen_q   <= blk_pg.gen;
    end
  end

  // ---------------- assertions ----------------
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: outputs cleared after a reset edge
  always @(negedge clk) begin
    if (rst_q) begin
      p_clear_r1: assert (sum_q == '0 && !carry_out_q && !blk_prop_q && !blk_gen_q)
        else $error("outputs not cleared by reset");
    end
  end

  // R2: registered sum matches integer addition
  p_sum_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sum_q == DATA_W'($past(a_in) + $past(b_in) + DATA_W'($past(carry_in))));

  // R3: carry-out matches bit DATA_W of the widened sum
  p_carry_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> carry_out_q == (({1'b0, $past(a_in)} + {1'b0, $past(b_in)}
                              + {{DATA_W{1'b0}}, $past(carry_in)}) >> DATA_W) );

  // R4: block propagate means every bit position propagates
  p_prop_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> blk_prop_q == &($past(a_in) | $past(b_in)));

  // R5: block generate means a carry without any carry-in
  p_gen_r5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> blk_gen_q == ((({1'b0, $past(a_in)} + {1'b0, $past(b_in)}) >> DATA_W) != 0));

endmodule

// File: tb/cla16_adder_tb.sv
`timescale 1ns/1ps
module cla16_adder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a_in = '0;
  logic [15:0] b_in = '0;
  logic        carry_in = 1'b0;
  logic [15:0] sum_q;
  logic        carry_out_q;
  logic        blk_prop_q;
  logic        blk_gen_q;

  always #2 clk = ~clk;  // 250 MHz

  cla16_adder u_dut (
    .clk         (clk),
    .rst         (rst),
    .a_in        (a_in),
    .b_in        (b_in),
    .carry_in    (carry_in),
    .sum_q       (sum_q),
    .carry_out_q (carry_out_q),
    .blk_prop_q  (blk_prop_q),
    .blk_gen_q   (blk_gen_q)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_tag = "R1";

  // Behavioural reference, advanced on every clock.
  logic [15:0] exp_sum;
  logic        exp_cout, exp_p, exp_g, exp_cin, exp_valid = 1'b0, exp_rst;
  string       exp_tag;

  always @(posedge clk) begin
    int unsigned tot, raw;
    tot = int'(a_in) + int'(b_in) + int'(carry_in);
    raw = int'(a_in) + int'(b_in);
    exp_valid <= 1'b1;
    exp_rst   <= rst;
    exp_cin   <= carry_in;
    exp_tag   <= rst ? "R1" : cur_tag;
    if (rst) begin
      exp_sum <= '0; exp_cout <= 1'b0; exp_p <= 1'b0; exp_g <= 1'b0;
    end else begin
      exp_sum  <= tot[15:0];
      exp_cout <= tot > 32'hFFFF;
      exp_p    <= (a_in | b_in) == 16'hFFFF;
      exp_g    <= raw > 32'hFFFF;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (exp_valid && !done) begin
      if (exp_rst) begin
        chk("R1", "reset sum", int'(sum_q), 0);
        chk("R1", "reset flags", int'({carry_out_q, blk_prop_q, blk_gen_q}), 0);
      end else begin
        chk({exp_tag, "/R2"}, "sum", int'(sum_q), int'(exp_sum));
        chk({exp_tag, "/R3"}, "carry_out", int'(carry_out_q), int'(exp_cout));
        chk({exp_tag, "/R4"}, "blk_prop", int'(blk_prop_q), int'(exp_p));
        chk({exp_tag, "/R5"}, "blk_gen", int'(blk_gen_q), int'(exp_g));
        chk({exp_tag, "/R6"}, "cout vs G|P&cin", int'(carry_out_q),
            int'(blk_gen_q | (blk_prop_q & exp_cin)));
      end
    end
  end

  task automatic drive(logic [15:0] a, logic [15:0] b, logic c, string tag);
    @(negedge clk);
    cur_tag  = tag;
    a_in     = a;
    b_in     = b;
    carry_in = c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R7: carry crossing every group in one cycle
    drive(16'hFFFF, 16'h0000, 1'b1, "R7");
    drive(16'h0000, 16'hFFFF, 1'b1, "R7");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R7");
    drive(16'hFFFF, 16'hFFFF, 1'b0, "R7");
    drive(16'h0000, 16'h0000, 1'b0, "R7");
    drive(16'h8000, 16'h8000, 1'b0, "R7");

    // R8: each group swept exhaustively, others propagating or zero
    for (int k = 0; k < 4; k++) begin
      for (int mode = 0; mode < 2; mode++) begin
        for (int v = 0; v < 512; v++) begin
          logic [15:0] a, b;
          a = (mode == 0) ? 16'hFFFF : 16'h0000;
          b = 16'h0000;
          a[k*4 +: 4] = v[3:0];
          b[k*4 +: 4] = v[7:4];
          drive(a, b, v[8], "R8");
        end
      end
    end

    // Random vectors
    for (int i = 0; i < 2000; i++)
      drive(16'($urandom), 16'($urandom), 1'($urandom), "R2");

    // R1: reset in mid-stream clears outputs
    drive(16'h1234, 16'hFEDC, 1'b1, "R1");
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive(16'h0F0F, 16'hF0F1, 1'b0, "R2");
    repeat (3) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule